// File: doc/BRIEF.md
# Multiplexed latching bus exchanger

The block joins one narrow A port to two B banks of the same width through four transparent storage latches. Data coming from the B side passes through a separate latch for each bank. A select input then picks which bank's latch output goes toward A. Data coming from A is fanned out into two latches, one per B bank, so each bank can capture a different A value at a different time. Address and data words can be merged onto one path this way, or split off it, as in interleaved memory or multiplexed address/data buses.

Each port has an active-low output enable. Instead of tri-state pins, every port presents three things: the value its logic drives, a positive drive flag, and an effective pin value. The pin value is the driven value while the port is enabled. Otherwise it is a bus-hold keeper value: the last value the port actively drove. The latches are level-sensitive in behaviour, so an open latch is transparent in the same cycle. Storage is built from edge-triggered registers: an open latch's register takes its input on every rising clock edge. When the enable falls, the value held is the one sampled at the last edge while the enable was high. The control pins are plain levels; the block has no streaming handshake.

Top module: `xch_exchanger`

## Requirements
- R1: While reset is asserted (rst_n low), all four latch stores and all three keepers are cleared to zero. With every latch enable low and every port enabled, all data outputs and pins read zero.
- R2: A latch whose enable is high is transparent: its output equals its data input in the same cycle.
- R3: A latch whose enable is low outputs the input value it sampled at the last rising clock edge at which its enable was high. Input changes while the enable is low have no effect on it.
- R4: The four latches are independent. le_ba1 controls the b1-to-A latch, le_ba2 the b2-to-A latch, le_ab1 the A-to-b1 latch and le_ab2 the A-to-b2 latch.
- R5: a_out equals the b1-to-A latch output when sel_b1 is 1, and the b2-to-A latch output when sel_b1 is 0.
- R6: Each output enable is active low. The port's drive flag (a_oe, b1_oe, b2_oe) is 1 exactly when its *_n enable input is 0.
- R7: The two B enables act independently, so neither bank, either bank alone, or both banks may drive at once.
- R8: A port's pin equals its driven value while its drive flag is 1. While the flag is 0, the pin holds the driven value sampled at the last rising edge at which the flag was 1, or zero if there was no such edge since reset.
- R9: Both transfer directions are computed at all times, including when A and a B bank are enabled together; avoiding contention is left to the system around the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch stores and keepers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Data arriving on port A |
| b1_in | input | W | Data arriving on bank 1 |
| b2_in | input | W | Data arriving on bank 2 |
| le_ba1 | input | 1 | Opens the bank-1-to-A latch |
| le_ba2 | input | 1 | Opens the bank-2-to-A latch |
| le_ab1 | input | 1 | Opens the A-to-bank-1 latch |
| le_ab2 | input | 1 | Opens the A-to-bank-2 latch |
| sel_b1 | input | 1 | 1 routes bank 1 toward A, 0 routes bank 2 |
| oe_a_n | input | 1 | Active-low drive enable for A |
| oe_b1_n | input | 1 | Active-low drive enable for bank 1 |
| oe_b2_n | input | 1 | Active-low drive enable for bank 2 |
| a_out | output | W | Value driven toward A |
| a_oe | output | 1 | A is being driven |
| a_pin | output | W | Effective A pin value, with the keeper |
| b1_out | output | W | Value driven toward bank 1 |
| b1_oe | output | 1 | Bank 1 is being driven |
| b1_pin | output | W | Effective bank 1 pin value |
| b2_out | output | W | Value driven toward bank 2 |
| b2_oe | output | 1 | Bank 2 is being driven |
| b2_pin | output | W | Effective bank 2 pin value |

## Verification
The bench sweeps all 256 combinations of the four latch enables, the select and the three output enables, twice over. Each pass uses different data words, so a held value can be told apart from a transparent one, and bank 1 can be told apart from bank 2. Because the sweep passes through many enable histories, stale keeper and latch contents are checked against a reference model computed in the bench. Short directed sequences add a latch that closes and then sees new input, and a port that is disabled right after driving.

// File: rtl/xch_pkg.sv
package xch_pkg;
  localparam int NBANK = 2;
  typedef enum logic {SEL_BANK2 = 1'b0, SEL_BANK1 = 1'b1} bank_sel_e;
endpackage

// File: rtl/xch_latch.sv
module xch_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held <= '0;
    else if (le) held <= d;
  end

  assign q = le ? d : held;
endmodule

// File: rtl/xch_port.sv
module xch_port #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic [W-1:0] drv,
  output logic         oe,
  output logic [W-1:0] pin
);
  logic [W-1:0] keep;

  assign oe = ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  keep <= '0;
    else if (oe) keep <= drv;
  end

  assign pin = oe ? drv : keep;
endmodule

// File: rtl/xch_exchanger.sv
module xch_exchanger #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         le_ba1,
  input  logic         le_ba2,
  input  logic         le_ab1,
  input  logic         le_ab2,
  input  logic         sel_b1,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] a_pin,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  output logic [W-1:0] b1_pin,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  output logic [W-1:0] b2_pin
);
  import xch_pkg::*;

  logic [W-1:0] bank_in  [NBANK];
  logic [W-1:0] ba_q     [NBANK];
  logic [W-1:0] ab_q     [NBANK];
  logic         le_ba    [NBANK];
  logic         le_ab    [NBANK];
  logic         oe_b_n   [NBANK];
  logic         oe_b     [NBANK];
  logic [W-1:0] b_pin    [NBANK];
  logic         pick_b1;

  assign bank_in[0] = b1_in;
  assign bank_in[1] = b2_in;
  assign le_ba[0]   = le_ba1;
  assign le_ba[1]   = le_ba2;
  assign le_ab[0]   = le_ab1;
  assign le_ab[1]   = le_ab2;
  assign oe_b_n[0]  = oe_b1_n;
  assign oe_b_n[1]  = oe_b2_n;

  // One pair of latches and one port driver per bank
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    xch_latch #(.W(W)) u_ba (
      .clk(clk), .rst_n(rst_n), .le(le_ba[g]), .d(bank_in[g]), .q(ba_q[g]));
    xch_latch #(.W(W)) u_ab (
      .clk(clk), .rst_n(rst_n), .le(le_ab[g]), .d(a_in), .q(ab_q[g]));
    xch_port #(.W(W)) u_bport (
      .clk(clk), .rst_n(rst_n), .oe_n(oe_b_n[g]), .drv(ab_q[g]),
      .oe(oe_b[g]), .pin(b_pin[g]));
  end

  assign pick_b1 = (bank_sel_e'(sel_b1) == SEL_BANK1);

  // Bit-sliced merge toward A
  for (genvar i = 0; i < W; i++) begin : g_slice
    assign a_out[i] = pick_b1 ? ba_q[0][i] : ba_q[1][i];
  end

  xch_port #(.W(W)) u_aport (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_a_n), .drv(a_out),
    .oe(a_oe), .pin(a_pin));

  assign b1_out = ab_q[0];
  assign b2_out = ab_q[1];
  assign b1_oe  = oe_b[0];
  assign b2_oe  = oe_b[1];
  assign b1_pin = b_pin[0];
  assign b2_pin = b_pin[1];
endmodule

// File: rtl/xch_exchanger_chk.sv
module xch_exchanger_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b2_in,
  input logic         le_ba1,
  input logic         le_ba2,
  input logic         le_ab1,
  input logic         le_ab2,
  input logic         sel_b1,
  input logic         oe_a_n,
  input logic         oe_b1_n,
  input logic         oe_b2_n,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] a_pin,
  input logic [W-1:0] b1_out,
  input logic         b1_oe,
  input logic [W-1:0] b1_pin,
  input logic [W-1:0] b2_out,
  input logic         b2_oe,
  input logic [W-1:0] b2_pin
);
  a_r2_open_b1: assert property (@(posedge clk) disable iff (!rst_n)
    le_ab1 |-> b1_out == a_in);
  a_r3_closed_b2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab2 && $past(!le_ab2)) |-> $stable(b2_out));
  a_r5_sel_bank1: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ba1 && sel_b1) |-> a_out == b1_in);
  a_r5_sel_bank2: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ba2 && !sel_b1) |-> a_out == b2_in);
  a_r8_pin_driven: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe |-> a_pin == a_out);
  a_r8_keeper_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!b1_oe && $past(b1_oe)) |-> b1_pin == $past(b1_out));
  a_r8_keeper_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (!b2_oe && $past(!b2_oe)) |-> $stable(b2_pin));
  a_r6_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe != oe_a_n);
endmodule

bind xch_exchanger xch_exchanger_chk #(.W(W)) u_chk (.*);

// File: tb/tb_xch_exchanger.sv
module tb_xch_exchanger;
  localparam int W = 12;
  localparam logic [W-1:0] M = '1;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = 0, b1_in = 0, b2_in = 0;
  logic le_ba1 = 0, le_ba2 = 0, le_ab1 = 0, le_ab2 = 0, sel_b1 = 0;
  logic oe_a_n = 0, oe_b1_n = 0, oe_b2_n = 0;
  logic [W-1:0] a_out, a_pin, b1_out, b1_pin, b2_out, b2_pin;
  logic a_oe, b1_oe, b2_oe;

  int checks = 0, errors = 0;
  logic [W-1:0] st_ba1 = 0, st_ba2 = 0, st_ab1 = 0, st_ab2 = 0;
  logic [W-1:0] kp_a = 0, kp_b1 = 0, kp_b2 = 0;

  always #4 clk = ~clk;

  xch_exchanger #(.W(W)) dut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check, then step the reference over one rising edge
  task automatic step(input logic [7:0] c, input logic [W-1:0] a, input logic [W-1:0] b1,
                      input logic [W-1:0] b2);
    logic [W-1:0] e_ba1, e_ba2, e_ab1, e_ab2, e_a;
    @(negedge clk);
    {le_ba1, le_ba2, le_ab1, le_ab2, sel_b1, oe_a_n, oe_b1_n, oe_b2_n} = c;
    a_in = a; b1_in = b1; b2_in = b2;
    #1;
    e_ba1 = le_ba1 ? b1 : st_ba1;
    e_ba2 = le_ba2 ? b2 : st_ba2;
    e_ab1 = le_ab1 ? a : st_ab1;
    e_ab2 = le_ab2 ? a : st_ab2;
    e_a   = sel_b1 ? e_ba1 : e_ba2;
    chk("R5 a_out", a_out, e_a);
    chk("R4 b1_out", b1_out, e_ab1);
    chk("R4 b2_out", b2_out, e_ab2);
    chk("R6 a_oe", W'(a_oe), W'(!oe_a_n));
    chk("R7 b1_oe", W'(b1_oe), W'(!oe_b1_n));
    chk("R7 b2_oe", W'(b2_oe), W'(!oe_b2_n));
    chk("R8 a_pin", a_pin, oe_a_n ? kp_a : e_a);
    chk("R8 b1_pin", b1_pin, oe_b1_n ? kp_b1 : e_ab1);
    chk("R8 b2_pin", b2_pin, oe_b2_n ? kp_b2 : e_ab2);
    @(posedge clk);
    if (le_ba1) st_ba1 = b1;
    if (le_ba2) st_ba2 = b2;
    if (le_ab1) st_ab1 = a;
    if (le_ab2) st_ab2 = a;
    if (!oe_a_n)  kp_a  = e_a;
    if (!oe_b1_n) kp_b1 = e_ab1;
    if (!oe_b2_n) kp_b2 = e_ab2;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a_in = 12'h5A5; b1_in = 12'hA5A; b2_in = 12'h3C3;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 a_out", a_out, '0);
    chk("R1 b1_out", b1_out, '0);
    chk("R1 b2_out", b2_out, '0);
    chk("R1 b1_pin", b1_pin, '0);
    @(negedge clk); oe_a_n = 1; oe_b1_n = 1; oe_b2_n = 1; #1;
    chk("R1 a_pin keeper", a_pin, '0);
    chk("R1 b2_pin keeper", b2_pin, '0);
    @(negedge clk); rst_n = 1;

    // R3: close A-to-b1 latch then change A; R2: open latch follows at once
    step(8'b0010_0111, 12'h123, 12'h000, 12'h000);
    step(8'b0000_0000, 12'hFED, 12'h000, 12'h000);
    chk("R3 b1 held", b1_out, 12'h123);
    step(8'b0001_0000, 12'h456, 12'h000, 12'h000);
    chk("R2 b2 transparent", b2_out, 12'h456);
    chk("R3 b1 still held", b1_out, 12'h123);

    // R9: A and both banks enabled together, both directions live
    step(8'b1111_1000, 12'h0F0, 12'h111, 12'h222);
    chk("R9 a_out with B driving", a_out, 12'h111);
    chk("R9 b1_out with A driving", b1_out, 12'h0F0);

    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 256; k++) begin
        int s = k + 256 * p;
        step(8'(k), W'((s * 37 + 5) & M), W'((s * 91 + 700) & M), W'((s * 53 + 1234) & M));
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule